// File: doc/BRIEF.md
# Two-Bit Up/Down Counter with Coded Clear

This block is a synchronous 2-bit counter steered by a pair of control inputs. At every rising clock edge the two inputs form a code that selects one of four actions: keep the present value, step up by one, step down by one, or return to zero. The count wraps in both directions.

The state flops have no reset pin. The counter therefore has no defined value after power-up until the surrounding logic presents the clear code for one clock edge. From then on the count is known and follows the codes applied at each edge. The output is the state register itself, with no decoding after it. It changes only at rising clock edges.

Top module: `updown_cnt2`

## Requirements
- R1: With mode_a=0 and mode_b=0 at a rising edge, count keeps its present value.
- R2: With mode_a=0 and mode_b=1 at a rising edge, count advances by one and wraps, following 00, 01, 10, 11, 00.
- R3: With mode_a=1 and mode_b=0 at a rising edge, count becomes 00 whatever its present value.
- R4: With mode_a=1 and mode_b=1 at a rising edge, count steps back by one and wraps, following 00, 11, 10, 01, 00.
- R5: mode_a and mode_b are sampled only at the rising clock edge, so changes between edges have no effect on count.
- R6: count is driven straight from the state register, so it changes only just after a rising edge and never follows an input change between edges.
- R7: The state has no reset input and starts unknown. A single edge carrying the clear code gives a known 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mode_a | input | 1 | Upper bit of the action code |
| mode_b | input | 1 | Lower bit of the action code |
| count | output | 2 | Present counter state |

## Verification
The assertions assume that mode_a and mode_b hold known values at every rising edge. Those that compare the count with its previous value also assume the count was known one edge earlier. Each of these checks is switched off while its inputs contain X or Z, so the undefined period before the first clear raises no error. The bench opens with a clear and drives both controls at every edge from then on. Inputs change only just after a falling edge, and the one deliberate glitch is removed before the next rising edge.

// File: rtl/updown_cnt2.sv
module updown_cnt2 (
  input  logic       clk,
  input  logic       mode_a,
  input  logic       mode_b,
  output logic [1:0] count
);

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'b00,
    ACT_UP    = 2'b01,
    ACT_CLEAR = 2'b10,
    ACT_DOWN  = 2'b11
  } act_t;

  act_t       act;
  logic [1:0] cnt_q;
  logic [1:0] cnt_d;

  assign act = act_t'({mode_a, mode_b});

  always_comb begin
    case (act)
      ACT_HOLD:  cnt_d = cnt_q;
      ACT_UP:    cnt_d = cnt_q + 2'd1;
      ACT_CLEAR: cnt_d = 2'b00;
      default:   cnt_d = cnt_q - 2'd1;
    endcase
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign count = cnt_q;

  // R1
  hold_keeps_chk: assert property (@(posedge clk)
    disable iff ($isunknown({mode_a, mode_b, count}))
    (!mode_a && !mode_b) |=> $stable(count));

  // R2
  up_step_chk: assert property (@(posedge clk)
    disable iff ($isunknown({mode_a, mode_b, count}))
    (!mode_a && mode_b) |=> (count == 2'($past(count) + 2'd1)));

  // R3
  clear_zero_chk: assert property (@(posedge clk)
    disable iff ($isunknown({mode_a, mode_b}))
    (mode_a && !mode_b) |=> (count == 2'b00));

  // R4
  down_step_chk: assert property (@(posedge clk)
    disable iff ($isunknown({mode_a, mode_b, count}))
    (mode_a && mode_b) |=> (count == 2'($past(count) - 2'd1)));

  // R7
  clear_known_chk: assert property (@(posedge clk)
    disable iff ($isunknown({mode_a, mode_b}))
    (mode_a && !mode_b) |=> !$isunknown(count));

endmodule

// File: tb/updown_cnt2_tb.sv
module updown_cnt2_tb;
  logic       clk = 1'b0;
  logic       mode_a = 1'b1;
  logic       mode_b = 1'b0;
  logic [1:0] count;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  updown_cnt2 u_dut (.clk(clk), .mode_a(mode_a), .mode_b(mode_b), .count(count));

  always #10 clk = ~clk;

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic a, input logic b);
    if (!a && !b) return s;
    if (!a && b)  return 2'(s + 2'd1);
    if (a && !b)  return 2'b00;
    return 2'(s - 2'd1);
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    n_chk++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%b expected=%b", req, count, exp);
    end
  endtask

  task automatic step(input logic a, input logic b);
    mode_a = a;
    mode_b = b;
    @(negedge clk);
  endtask

  task automatic go_to(input logic [1:0] s);
    step(1'b1, 1'b0);
    for (int i = 0; i < int'(s); i++) step(1'b0, 1'b1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: count=%b expected=done", count);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R7: first clear edge from the undefined state
    step(1'b1, 1'b0);
    check("R7", 2'b00);

    // exhaustive present-state by code sweep (R1..R4)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] exp;
        go_to(2'(s));
        exp = ref_next(2'(s), c[1], c[0]);
        step(c[1], c[0]);
        case (c)
          0: check("R1", exp);
          1: check("R2", exp);
          2: check("R3", exp);
          default: check("R4", exp);
        endcase
      end
    end

    // R2: full upward cycle with wrap
    go_to(2'd0);
    for (int i = 1; i <= 5; i++) begin
      step(1'b0, 1'b1);
      check("R2", 2'(i));
    end

    // R4: full downward cycle with wrap
    go_to(2'd0);
    for (int i = 1; i <= 5; i++) begin
      step(1'b1, 1'b1);
      check("R4", 2'(-i));
    end

    // R1: long hold
    go_to(2'd3);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0);
      check("R1", 2'd3);
    end

    // R5/R6: glitch the controls between edges
    go_to(2'd2);
    mode_a = 1'b1;
    mode_b = 1'b0;
    #2;
    check("R6", 2'd2);
    mode_a = 1'b1;
    mode_b = 1'b1;
    #2;
    check("R6", 2'd2);
    mode_a = 1'b0;
    mode_b = 1'b0;
    @(negedge clk);
    check("R5", 2'd2);

    // R3: clear from every state again after a mix of codes
    for (int s = 0; s < 4; s++) begin
      go_to(2'(s));
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      check("R3", 2'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule